// File: doc/BRIEF.md
# Transceiver Reconfiguration Sequencer

This block runs the safe order of steps around a live reconfiguration of one serial transceiver channel or the transmit PLL that feeds it. A start request comes with a target type and a flag that says whether the change touches line rate, protocol mode or the pattern generator. The sequencer puts the affected paths into digital reset. When the flag is set, it then adds analog reset. It then gets hold of the shared configuration bus, which the calibration processor may be holding. Once it has the bus, it hands the actual register writes to an external write engine through a start/done handshake.

After the writes finish, the sequencer returns the bus and, for rate changes, asks for recalibration of the paths involved. It waits for the calibration busy input to fall. It then releases analog reset first and digital reset last, and reports completion. The bus wait and the calibration wait each have a timeout. On a timeout the sequencer flags an error and goes back to idle with the resets still applied, so a broken link is never brought up half configured.

Top module: `xcvr_reconfig_seq`

## Requirements
- R1: On an accepted start, digital reset is applied before any other action, on paths chosen by `target`: 0 (PLL) and 1 (TX only) reset TX, 2 (RX only) resets RX, 3 (duplex) resets both.
- R2: Analog reset is applied only when `rateChange` was high at start. It covers the same paths as digital reset and comes after digital reset.
- R3: After any reset output changes, the sequencer waits at least `minHold` cycles before its next step. A `minHold` of 0 counts as 1.
- R4: If `busOwnedByCal` is high at the bus check, `busReq` rises and `writeStart` follows only after `busGrant`. Otherwise `writeStart` is issued and `busReq` stays low.
- R5: `writeStart` is a single-cycle pulse, issued once per sequence. The sequencer waits in the write phase until `writeDone`.
- R6: `busReq` falls after `writeDone` and before `calReq` rises.
- R7: With `rateChange`, `calReq` bits {RX, TX, PLL} are: target 0 gives 011, 1 gives 010, 2 gives 100, 3 gives 110. `calReq` is held until `calBusy` is seen high. Completion then waits for `calBusy` low. Without `rateChange`, `calReq` stays 0.
- R8: Analog reset is released before digital reset, separated by at least `minHold` cycles. `done` is a one-cycle pulse with `busy` low and all resets released.
- R9: If the bus wait or the calibration wait lasts `TIMEOUT_CYC` cycles, `errTimeout` goes high and `busy` low, with `busReq` and `calReq` low and the resets still applied. `errTimeout` clears on the next accepted start.
- R10: `busy` is high whenever the sequencer is not idle. A `startReq` while busy is ignored and leaves no pending start.
- R11: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start a reconfiguration sequence |
| target | input | 2 | Target type: 0 PLL, 1 TX, 2 RX, 3 duplex |
| rateChange | input | 1 | Change affects rate, protocol or pattern generator |
| minHold | input | HOLD_W | Minimum cycles between reset steps |
| busOwnedByCal | input | 1 | Calibration processor currently owns the configuration bus |
| busGrant | input | 1 | Bus granted to the sequencer |
| busReq | output | 1 | Bus request to the calibration processor |
| writeStart | output | 1 | Start pulse to the write engine |
| writeDone | input | 1 | Write engine finished |
| calReq | output | 3 | Recalibration request {RX, TX, PLL} |
| calBusy | input | 1 | Calibration in progress |
| txDigRst | output | 1 | TX digital reset |
| rxDigRst | output | 1 | RX digital reset |
| txAnaRst | output | 1 | TX analog reset |
| rxAnaRst | output | 1 | RX analog reset |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | Sequence completed (pulse) |
| errTimeout | output | 1 | Bus or calibration wait timed out |

## Verification
The bench builds the block with `HOLD_W` = 4 and `TIMEOUT_CYC` = 24. At these values both timeout paths fire within a few dozen cycles, and every hold length in the sweep is reachable. It sweeps all four target types against both `rateChange` values, both bus-ownership cases and two `minHold` values, and measures the spacing and order of every reset, bus, write and calibration event in each run. It also forces a missing grant and a calibration that never starts, to check the error exit, the reset state that is left behind, and the clearing of the error flag on the next start.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DIG_HOLD,
    ST_ANA_HOLD,
    ST_BUS_CHK,
    ST_BUS_WAIT,
    ST_WRITE,
    ST_BUS_REL,
    ST_CAL_START,
    ST_CAL_WAIT,
    ST_ANA_REL
  } seq_state_t;

  // target encoding seen on the port
  localparam logic [1:0] TGT_PLL    = 2'd0;
  localparam logic [1:0] TGT_TX     = 2'd1;
  localparam logic [1:0] TGT_RX     = 2'd2;
  localparam logic [1:0] TGT_DUPLEX = 2'd3;

  localparam int NUM_PATHS = 2; // index 0 = TX, 1 = RX

  typedef struct packed {
    logic latchReq;
    logic clrCnt;
    logic setDig;
    logic clrDig;
    logic setAna;
    logic clrAna;
    logic setBus;
    logic clrBus;
    logic fireWrite;
    logic setCal;
    logic clrCal;
    logic setErr;
    logic clrErr;
    logic fireDone;
  } seq_strb_t;

endpackage

// File: rtl/xrs_ctrl.sv
module xrs_ctrl
  import xrs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      rateQ,
  input  logic      busOwnedByCal,
  input  logic      busGrant,
  input  logic      writeDone,
  input  logic      calBusy,
  input  logic      holdDone,
  input  logic      timeout,
  output seq_strb_t strb,
  output logic      busy
);

  seq_state_t st, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt  = st;
    strb = '0;
    unique case (st)
      ST_IDLE: begin
        if (startReq) begin
          strb.latchReq = 1'b1;
          strb.clrErr   = 1'b1;
          strb.setDig   = 1'b1;
          nxt           = ST_DIG_HOLD;
        end
      end
      ST_DIG_HOLD: begin
        if (holdDone) begin
          if (rateQ) begin
            strb.setAna = 1'b1;
            nxt         = ST_ANA_HOLD;
          end else begin
            nxt = ST_BUS_CHK;
          end
        end
      end
      ST_ANA_HOLD: begin
        if (holdDone) nxt = ST_BUS_CHK;
      end
      ST_BUS_CHK: begin
        if (busOwnedByCal) begin
          strb.setBus = 1'b1;
          nxt         = ST_BUS_WAIT;
        end else begin
          strb.fireWrite = 1'b1;
          nxt            = ST_WRITE;
        end
      end
      ST_BUS_WAIT: begin
        if (busGrant) begin
          strb.fireWrite = 1'b1;
          nxt            = ST_WRITE;
        end else if (timeout) begin
          strb.clrBus = 1'b1;
          strb.setErr = 1'b1;
          nxt         = ST_IDLE;
        end
      end
      ST_WRITE: begin
        if (writeDone) begin
          strb.clrBus = 1'b1;
          nxt         = ST_BUS_REL;
        end
      end
      ST_BUS_REL: begin
        if (rateQ) begin
          strb.setCal = 1'b1;
          nxt         = ST_CAL_START;
        end else begin
          strb.clrAna   = 1'b1;
          strb.clrDig   = 1'b1;
          strb.fireDone = 1'b1;
          nxt           = ST_IDLE;
        end
      end
      ST_CAL_START: begin
        if (calBusy) begin
          strb.clrCal = 1'b1;
          nxt         = ST_CAL_WAIT;
        end else if (timeout) begin
          strb.clrCal = 1'b1;
          strb.setErr = 1'b1;
          nxt         = ST_IDLE;
        end
      end
      ST_CAL_WAIT: begin
        if (!calBusy) begin
          strb.clrAna = 1'b1;
          nxt         = ST_ANA_REL;
        end else if (timeout) begin
          strb.setErr = 1'b1;
          nxt         = ST_IDLE;
        end
      end
      ST_ANA_REL: begin
        if (holdDone) begin
          strb.clrAna   = 1'b1;
          strb.clrDig   = 1'b1;
          strb.fireDone = 1'b1;
          nxt           = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
    strb.clrCnt = (nxt != st);
  end

  assign busy = (st != ST_IDLE);

endmodule

// File: rtl/xrs_dp.sv
module xrs_dp
  import xrs_pkg::*;
#(
  parameter int HOLD_W      = 8,
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strb_t         strb,
  input  logic [1:0]        targetIn,
  input  logic              rateIn,
  input  logic [HOLD_W-1:0] minHold,
  output logic              rateQ,
  output logic              holdDone,
  output logic              timeout,
  output logic [1:0]        digRst,
  output logic [1:0]        anaRst,
  output logic              busReq,
  output logic              writeStart,
  output logic [2:0]        calReq,
  output logic              done,
  output logic              errTimeout
);

  localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);
  localparam int CNT_W = (TO_W > HOLD_W) ? TO_W : HOLD_W;
  localparam logic [CNT_W-1:0] TO_LIM = CNT_W'(TIMEOUT_CYC - 1);

  logic [1:0]       tgtQ, tgtNow;
  logic [CNT_W-1:0] cnt, holdLim;
  logic [1:0]       pathSel;
  logic [2:0]       calSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtQ  <= TGT_PLL;
      rateQ <= 1'b0;
    end else if (strb.latchReq) begin
      tgtQ  <= targetIn;
      rateQ <= rateIn;
    end
  end

  assign tgtNow = strb.latchReq ? targetIn : tgtQ;

  // path selection: [0] TX, [1] RX
  assign pathSel[0] = (tgtNow != TGT_RX);
  assign pathSel[1] = (tgtNow == TGT_RX) || (tgtNow == TGT_DUPLEX);
  // recalibration selection: {RX, TX, PLL}
  assign calSel = {pathSel[1], pathSel[0], (tgtQ == TGT_PLL)};

  // shared step counter, saturating
  always_ff @(posedge clk) begin
    if (!rstN || strb.clrCnt) cnt <= '0;
    else if (cnt != '1)       cnt <= cnt + 1'b1;
  end

  assign holdLim  = (minHold == '0) ? '0 : CNT_W'(minHold) - 1'b1;
  assign holdDone = (cnt >= holdLim);
  assign timeout  = (cnt == TO_LIM);

  for (genvar gp = 0; gp < NUM_PATHS; gp++) begin : g_path
    always_ff @(posedge clk) begin
      if (!rstN)            digRst[gp] <= 1'b0;
      else if (strb.setDig) digRst[gp] <= digRst[gp] | pathSel[gp];
      else if (strb.clrDig) digRst[gp] <= 1'b0;
    end
    always_ff @(posedge clk) begin
      if (!rstN)            anaRst[gp] <= 1'b0;
      else if (strb.setAna) anaRst[gp] <= anaRst[gp] | pathSel[gp];
      else if (strb.clrAna) anaRst[gp] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busReq     <= 1'b0;
      writeStart <= 1'b0;
      calReq     <= '0;
      done       <= 1'b0;
      errTimeout <= 1'b0;
    end else begin
      writeStart <= strb.fireWrite;
      done       <= strb.fireDone;
      if (strb.setBus)      busReq <= 1'b1;
      else if (strb.clrBus) busReq <= 1'b0;
      if (strb.setCal)      calReq <= calSel;
      else if (strb.clrCal) calReq <= '0;
      if (strb.setErr)      errTimeout <= 1'b1;
      else if (strb.clrErr) errTimeout <= 1'b0;
    end
  end

endmodule

// File: rtl/xcvr_reconfig_seq.sv
module xcvr_reconfig_seq
  import xrs_pkg::*;
#(
  parameter int HOLD_W      = 8,
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [1:0]        target,
  input  logic              rateChange,
  input  logic [HOLD_W-1:0] minHold,
  input  logic              busOwnedByCal,
  input  logic              busGrant,
  output logic              busReq,
  output logic              writeStart,
  input  logic              writeDone,
  output logic [2:0]        calReq,
  input  logic              calBusy,
  output logic              txDigRst,
  output logic              rxDigRst,
  output logic              txAnaRst,
  output logic              rxAnaRst,
  output logic              busy,
  output logic              done,
  output logic              errTimeout
);

  seq_strb_t  strb;
  logic       rateQ, holdDone, timeout;
  logic [1:0] digRst, anaRst;

  xrs_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .startReq      (startReq),
    .rateQ         (rateQ),
    .busOwnedByCal (busOwnedByCal),
    .busGrant      (busGrant),
    .writeDone     (writeDone),
    .calBusy       (calBusy),
    .holdDone      (holdDone),
    .timeout       (timeout),
    .strb          (strb),
    .busy          (busy)
  );

  xrs_dp #(
    .HOLD_W      (HOLD_W),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .targetIn   (target),
    .rateIn     (rateChange),
    .minHold    (minHold),
    .rateQ      (rateQ),
    .holdDone   (holdDone),
    .timeout    (timeout),
    .digRst     (digRst),
    .anaRst     (anaRst),
    .busReq     (busReq),
    .writeStart (writeStart),
    .calReq     (calReq),
    .done       (done),
    .errTimeout (errTimeout)
  );

  assign txDigRst = digRst[0];
  assign rxDigRst = digRst[1];
  assign txAnaRst = anaRst[0];
  assign rxAnaRst = anaRst[1];

endmodule

// File: rtl/xcvr_reconfig_chk.sv
module xcvr_reconfig_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic       errTimeout,
  input logic       txDigRst,
  input logic       rxDigRst,
  input logic       txAnaRst,
  input logic       rxAnaRst,
  input logic       busReq,
  input logic       writeStart,
  input logic [2:0] calReq
);

  AST_TX_ANA_INSIDE_DIG: assert property (@(posedge clk) disable iff (!rstN)
    txAnaRst |-> txDigRst); // R2
  AST_RX_ANA_INSIDE_DIG: assert property (@(posedge clk) disable iff (!rstN)
    rxAnaRst |-> rxDigRst); // R8
  AST_WRITE_UNDER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    writeStart |-> (txDigRst || rxDigRst)); // R1
  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    writeStart |=> !writeStart); // R5
  AST_CAL_WITHOUT_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (calReq != 3'b000) |-> !busReq); // R6
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !txDigRst && !rxDigRst && !txAnaRst && !rxAnaRst)); // R8
  AST_ERR_KEEPS_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errTimeout) |-> ((txDigRst || rxDigRst) && !busy && !busReq && calReq == 3'b000)); // R9
  AST_DIG_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(txDigRst) || $rose(rxDigRst)) |-> !$past(busy)); // R10

endmodule

bind xcvr_reconfig_seq xcvr_reconfig_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busy),
  .done       (done),
  .errTimeout (errTimeout),
  .txDigRst   (txDigRst),
  .rxDigRst   (rxDigRst),
  .txAnaRst   (txAnaRst),
  .rxAnaRst   (rxAnaRst),
  .busReq     (busReq),
  .writeStart (writeStart),
  .calReq     (calReq)
);

// File: tb/sim_xcvr_reconfig_seq.sv
`timescale 1ns/1ps
module sim_xcvr_reconfig_seq;

  localparam int HW  = 4;
  localparam int TOC = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic [1:0]    target = 2'd0;
  logic          rateChange = 1'b0;
  logic [HW-1:0] minHold = 4'd1;
  logic          busOwnedByCal = 1'b0;
  logic          busGrant = 1'b0;
  logic          writeDone = 1'b0;
  logic          calBusy = 1'b0;
  logic          busReq, writeStart, txDigRst, rxDigRst, txAnaRst, rxAnaRst;
  logic          busy, done, errTimeout;
  logic [2:0]    calReq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  xcvr_reconfig_seq #(.HOLD_W(HW), .TIMEOUT_CYC(TOC)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .target(target),
    .rateChange(rateChange), .minHold(minHold), .busOwnedByCal(busOwnedByCal),
    .busGrant(busGrant), .busReq(busReq), .writeStart(writeStart),
    .writeDone(writeDone), .calReq(calReq), .calBusy(calBusy),
    .txDigRst(txDigRst), .rxDigRst(rxDigRst), .txAnaRst(txAnaRst),
    .rxAnaRst(rxAnaRst), .busy(busy), .done(done), .errTimeout(errTimeout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] expDig(input logic [1:0] t);
    case (t)
      2'd2:    return 2'b01;   // {tx,rx}
      2'd3:    return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic [2:0] expCal(input logic [1:0] t);
    case (t)
      2'd0:    return 3'b011;
      2'd1:    return 3'b010;
      2'd2:    return 3'b100;
      default: return 3'b110;
    endcase
  endfunction

  // mode 0 normal, 1 grant never comes, 2 calibration never starts
  task automatic runSeq(input logic [1:0] tgt, input bit rate, input bit own,
                        input int mh, input int mode);
    int cyc = 0;
    int tDig = -1, tAna = -1, tBr = -1, tBf = -1, tWr = -1, nWr = 0;
    int tCal = -1, tCalF = -1, tAnaRel = -1, tDigRel = -1, nDone = 0;
    int effMh = (mh == 0) ? 1 : mh;
    bit errSeen = 0, doneBusy = 0, sawWrongDig = 0;
    logic [1:0] digPat = 2'b00, anaPat = 2'b00;
    logic [2:0] calPat = 3'b000;
    @(negedge clk);
    target = tgt; rateChange = rate; minHold = HW'(mh);
    busOwnedByCal = own; startReq = 1'b1;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      cyc++;
      startReq = 1'b0;
      if (cyc == 3) begin  // R10: start while busy, other target
        startReq = 1'b1; target = tgt ^ 2'd1; rateChange = !rate;
      end
      if (cyc == 4) begin target = tgt; rateChange = rate; end
      if ((txDigRst || rxDigRst) && tDig < 0) begin tDig = cyc; digPat = {txDigRst, rxDigRst}; end
      if (tDig >= 0 && tDigRel < 0 && (txDigRst || rxDigRst) && {txDigRst, rxDigRst} != digPat) sawWrongDig = 1;
      if ((txAnaRst || rxAnaRst) && tAna < 0) begin tAna = cyc; anaPat = {txAnaRst, rxAnaRst}; end
      if (busReq && tBr < 0) tBr = cyc;
      if (tBr >= 0 && !busReq && tBf < 0) tBf = cyc;
      if (writeStart) begin nWr++; tWr = cyc; end
      if (calReq != 0 && tCal < 0) begin tCal = cyc; calPat = calReq; end
      if (tCal >= 0 && calReq == 0 && tCalF < 0) tCalF = cyc;
      if (tAna >= 0 && !txAnaRst && !rxAnaRst && tAnaRel < 0) tAnaRel = cyc;
      if (tDig >= 0 && !txDigRst && !rxDigRst && tDigRel < 0) tDigRel = cyc;
      if (done) begin nDone++; doneBusy = busy; end
      if (errTimeout) begin errSeen = 1; break; end
      if (done) break;
      busGrant  = own && busReq && (mode != 1) && (tBr >= 0) && (cyc >= tBr + 2);
      writeDone = (tWr >= 0) && (cyc == tWr + 3);
      calBusy   = (mode != 2) && (tCal >= 0) && (cyc >= tCal + 2) && (cyc <= tCal + 6);
    end
    busGrant = 0; writeDone = 0; calBusy = 0;

    // R1: digital reset first, on the right paths
    check(digPat == expDig(tgt) && !sawWrongDig, "R1 digital paths", digPat, expDig(tgt));
    check(tDig == 1, "R1 digital first", tDig, 1);
    // R2: analog only with rate change, after digital
    if (rate) check(anaPat == expDig(tgt), "R2 analog paths", anaPat, expDig(tgt));
    else      check(tAna < 0, "R2 no analog", tAna, -1);
    // R3: hold after first reset step
    if (rate) check(tAna - tDig >= effMh, "R3 dig hold", tAna - tDig, effMh);
    else if (mode != 1) check(tWr - tDig >= effMh, "R3 dig hold", tWr - tDig, effMh);

    if (mode == 1) begin
      check(errSeen, "R9 bus timeout flag", errSeen, 1);
      check(!busy && !busReq && calReq == 0, "R9 idle after timeout", {busy, busReq}, 0);
      check({txDigRst, rxDigRst} == expDig(tgt), "R9 resets kept", {txDigRst, rxDigRst}, expDig(tgt));
      check(nWr == 0, "R4 no write without grant", nWr, 0);
      return;
    end
    if (mode == 2) begin
      check(errSeen, "R9 cal timeout flag", errSeen, 1);
      check(!busy && calReq == 0 && !busReq, "R9 idle after cal timeout", {busy, calReq}, 0);
      check({txAnaRst, rxAnaRst} == expDig(tgt) && {txDigRst, rxDigRst} == expDig(tgt),
            "R9 analog and digital kept", {txAnaRst, rxAnaRst}, expDig(tgt));
      return;
    end

    // R4: bus handshake
    if (own) check(tBr >= 0 && tWr == tBr + 3, "R4 write after grant", tWr - tBr, 3);
    else     check(tBr < 0 && tWr >= 0, "R4 no bus request", tBr, -1);
    // R5: exactly one write pulse
    check(nWr == 1, "R5 single write", nWr, 1);
    // R6: bus returned before calibration
    if (own) check(tBf == tWr + 4, "R6 bus drop after done", tBf - tWr, 4);
    if (own && rate) check(tBf < tCal, "R6 bus before cal", tBf, tCal);
    // R7: calibration request
    if (rate) begin
      check(calPat == expCal(tgt), "R7 cal paths", calPat, expCal(tgt));
      check(tCalF == tCal + 3, "R7 cal held until busy", tCalF - tCal, 3);
      check(tAnaRel > tCal + 6, "R7 wait busy low", tAnaRel, tCal + 7);
    end else check(tCal < 0, "R7 no cal", tCal, -1);
    // R8: release order and done
    if (rate) check(tDigRel - tAnaRel >= effMh, "R8 analog then digital", tDigRel - tAnaRel, effMh);
    check(nDone == 1 && !doneBusy && tDigRel == cyc, "R8 done clean", nDone, 1);
    check(!errTimeout, "R9 no error", errTimeout, 0);
    // R10: the start given while busy left nothing pending
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      check(!busy && !txDigRst && !rxDigRst, "R10 start ignored while busy", busy, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check({busReq, writeStart, calReq, txDigRst, rxDigRst, txAnaRst, rxAnaRst,
           busy, done, errTimeout} == 0, "R11 reset outputs", busy, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !txDigRst && !done, "R11 idle after reset", busy, 0);

    for (int t = 0; t < 4; t++)
      for (int r = 0; r < 2; r++)
        for (int o = 0; o < 2; o++)
          for (int m = 0; m < 2; m++)
            runSeq(2'(t), r[0], o[0], (m == 0) ? 0 : 3, 0);

    // R9: bus timeout, then error cleared by next start
    runSeq(2'd3, 1'b0, 1'b1, 2, 1);
    runSeq(2'd3, 1'b0, 1'b0, 2, 0);
    check(!errTimeout, "R9 error cleared on start", errTimeout, 0);

    // R9: calibration never starts
    runSeq(2'd0, 1'b1, 1'b0, 1, 2);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check(!errTimeout && !txDigRst && !txAnaRst, "R11 reset clears error", errTimeout, 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule